// File: doc/BRIEF.md
# Clock and USB Power-Up Sequencer

This block brings an on-chip PLL clock synthesizer and a USB function core out of reset in a fixed order. It first switches the synthesizer on and lets it settle. It then checks the lock flag until the PLL reports lock. If the board strap says so, it powers the internal line-driver regulator. Next it waits for the external capacitor to charge, for a time set by a capacitance value. Last, it enables the USB clock and, a few cycles later, the USB core.

All intervals count a 0.1 ms tick pulse that comes from outside. The capacitance input is in tenths of a microfarad, so the charge wait is that value plus ten ticks. A setting of 23 (2.3 µF) gives 33 ticks, or 3.3 ms. A poll counter stops the sequence and raises an error after a programmable number of failed lock checks. Requests to access the USB registers are granted only once the sequence has completed.

Top module: `usb_pwrup_seq`

## Requirements
- R1: While reset is active, every strobe output, the done flag and the error flag are 0, and the synthesizer mode field is 2'b11.
- R2: The synthesizer enable rises on the first clock edge after reset is released. The lock flag is first sampled only after 20 ticks have elapsed with the enable high.
- R3: A lock sample that reads 0 leads to a wait of exactly one tick and then a new sample. The mode field therefore stays 2'b11 for 20 plus the number of failed polls ticks.
- R4: The mode field changes from 2'b11 to 2'b10 only in the cycle after a lock sample that reads 1, and not at any other time.
- R5: With the regulator strap at 1, the regulator enable rises after lock is seen and never during the settle or poll phase. The driver current-control output stays at 0 at all times.
- R6: With the regulator strap at 0, the regulator enable stays at 0 for the whole sequence.
- R7: Between the mode change to 2'b10 and the USB clock enable, exactly `cap_tenths` + 10 ticks occur.
- R8: The USB core enable, together with the done flag, rises exactly 4 clock cycles after the USB clock enable. Both then stay high.
- R9: The access grant equals the access request while done is high, and is 0 while done is low.
- R10: When `lock_limit` is nonzero, a lock sample that reads 0 and is the `lock_limit`-th failed poll sets the error flag. The sequence then stops with the USB clock off. A lock seen on the last permitted poll still completes the sequence. A `lock_limit` of 0 turns the timeout off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle pulse every 0.1 ms |
| pll_lock | input | 1 | Lock flag from the synthesizer |
| use_reg | input | 1 | Strap: 1 = power the internal regulator, 0 = skip that step (3.3 V supply) |
| cap_tenths | input | 8 | External capacitance in tenths of a microfarad |
| lock_limit | input | 8 | Number of failed polls that raises the error flag; 0 turns the timeout off |
| usb_acc_req | input | 1 | Request to access the USB registers |
| syn_en | output | 1 | Synthesizer enable |
| syn_mode | output | 2 | Synthesizer mode field |
| ldo_en | output | 1 | Line-driver regulator enable |
| ldo_curr_hi | output | 1 | Driver current-control output, held at 0 |
| usb_clk_en | output | 1 | USB clock enable |
| usb_en | output | 1 | USB core enable |
| done | output | 1 | Sequence complete |
| lock_err | output | 1 | Lock timeout error |
| usb_acc_gnt | output | 1 | Access grant for the USB registers |

## Verification
A successful lock and the poll timeout can be decided in the same lock sample. The bench provokes this by raising the lock flag on exactly the `lock_limit`-th poll, and in a second case one poll too late. In the first case it expects completion with the error flag at 0 and `20 + failures` settle ticks. In the second case it expects the error flag set, the USB clock still off, and `20 + lock_limit - 1` ticks counted in the poll phase.

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq #(
  parameter int SETTLE_TICKS = 20,
  parameter int POLL_TICKS   = 1,
  parameter int CAP_BASE     = 10,
  parameter int USB_GAP      = 4,
  parameter int CAP_W        = 8,
  parameter int LIM_W        = 8,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pll_lock,
  input  logic             use_reg,
  input  logic [CAP_W-1:0] cap_tenths,
  input  logic [LIM_W-1:0] lock_limit,
  input  logic             usb_acc_req,
  output logic             syn_en,
  output logic [1:0]       syn_mode,
  output logic             ldo_en,
  output logic             ldo_curr_hi,
  output logic             usb_clk_en,
  output logic             usb_en,
  output logic             done,
  output logic             lock_err,
  output logic             usb_acc_gnt
);

  typedef enum logic [2:0] {
    S_CFG, S_SETTLE, S_CHECK, S_WAIT, S_REG, S_CAP, S_CLK, S_RUN
  } st_t;

  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);
  localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(POLL_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(USB_GAP - 1);

  st_t              st;
  logic             err_q;
  logic [CNT_W-1:0] cnt;
  logic [LIM_W-1:0] fails;
  logic [1:0]       mode_q;
  logic             ldo_q;

  wire [CNT_W-1:0] cap_last  = CNT_W'(cap_tenths) + CNT_W'(CAP_BASE - 1);
  wire [LIM_W:0]   fails_nxt = {1'b0, fails} + 1'b1;
  wire             timeout   = (lock_limit != '0) && (fails_nxt == {1'b0, lock_limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_CFG;
      err_q  <= 1'b0;
      cnt    <= '0;
      fails  <= '0;
      mode_q <= 2'b11;
      ldo_q  <= 1'b0;
    end else if (!err_q) begin
      case (st)
        S_CFG: begin
          st  <= S_SETTLE;
          cnt <= '0;
        end
        S_SETTLE: if (tick) begin
          if (cnt == SETTLE_LAST) begin
            st  <= S_CHECK;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CHECK: begin
          if (pll_lock) begin
            mode_q <= 2'b10;
            st     <= S_REG;
          end else if (timeout) begin
            err_q <= 1'b1;
          end else begin
            fails <= fails_nxt[LIM_W-1:0];
            st    <= S_WAIT;
            cnt   <= '0;
          end
        end
        S_WAIT: if (tick) begin
          if (cnt == POLL_LAST) begin
            st  <= S_CHECK;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_REG: begin
          ldo_q <= use_reg;
          st    <= S_CAP;
          cnt   <= '0;
        end
        S_CAP: if (tick) begin
          if (cnt == cap_last) begin
            st  <= S_CLK;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CLK: begin
          if (cnt == GAP_LAST) st <= S_RUN;
          else cnt <= cnt + 1'b1;
        end
        default: st <= st;
      endcase
    end
  end

  assign syn_en      = (st != S_CFG);
  assign syn_mode    = mode_q;
  assign ldo_en      = ldo_q;
  assign ldo_curr_hi = 1'b0;
  assign usb_clk_en  = (st == S_CLK) || (st == S_RUN);
  assign usb_en      = (st == S_RUN);
  assign done        = usb_en;
  assign lock_err    = err_q;
  assign usb_acc_gnt = usb_acc_req & done;

  p_mode_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_mode == 2'b10 && $past(syn_mode) == 2'b11) |-> $past(pll_lock));

  p_core_needs_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    usb_en |-> usb_clk_en);

  p_clk_before_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_en) |-> $past(usb_clk_en));

  p_ldo_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_en |-> (syn_en && syn_mode == 2'b10));

  p_err_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> (!usb_clk_en && syn_mode == 2'b11));

endmodule

// File: tb/test_usb_pwrup_seq.sv
module test_usb_pwrup_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       pll_lock = 1'b0;
  logic       use_reg = 1'b0;
  logic [7:0] cap_tenths = '0;
  logic [7:0] lock_limit = '0;
  logic       usb_acc_req = 1'b0;
  logic       syn_en, ldo_en, ldo_curr_hi, usb_clk_en, usb_en, done, lock_err, usb_acc_gnt;
  logic [1:0] syn_mode;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  usb_pwrup_seq i_usb_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pll_lock(pll_lock), .use_reg(use_reg),
    .cap_tenths(cap_tenths), .lock_limit(lock_limit), .usb_acc_req(usb_acc_req),
    .syn_en(syn_en), .syn_mode(syn_mode), .ldo_en(ldo_en), .ldo_curr_hi(ldo_curr_hi),
    .usb_clk_en(usb_clk_en), .usb_en(usb_en), .done(done), .lock_err(lock_err),
    .usb_acc_gnt(usb_acc_gnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // {use_reg, cap_tenths, lock failures before lock, lock_limit, expect error}
  localparam logic [25:0] VEC [7] = '{
    {1'b1, 8'd23,  8'd0,  8'd8, 1'b0},
    {1'b0, 8'd0,   8'd0,  8'd0, 1'b0},
    {1'b1, 8'd5,   8'd3,  8'd8, 1'b0},
    {1'b0, 8'd255, 8'd1,  8'd0, 1'b0},
    {1'b1, 8'd10,  8'd50, 8'd4, 1'b1},
    {1'b0, 8'd1,   8'd6,  8'd7, 1'b0},
    {1'b1, 8'd2,   8'd7,  8'd7, 1'b1}
  };

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0;
    pll_lock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input logic ur, input logic [7:0] cap, input int k,
                          input logic [7:0] lim, input logic experr);
    int ta = 0, tb = 0, gap = 0, n = 0;
    bit ldo_early = 0, drv_bad = 0, gnt_bad = 0;
    use_reg = ur;
    cap_tenths = cap;
    lock_limit = lim;
    usb_acc_req = 1'b1;
    do_reset();
    while (!(usb_en || lock_err) && n < 6000) begin
      @(negedge clk);
      n++;
      if (ta >= 20 + k) pll_lock = 1'b1;
      tick = (n % 4 == 0);
      if (syn_en && syn_mode == 2'b11 && !lock_err && tick) ta++;
      if (syn_mode == 2'b10 && !usb_clk_en && tick) tb++;
      if (usb_clk_en && !usb_en) gap++;
      if (ldo_en && syn_mode == 2'b11) ldo_early = 1;
      if (ldo_curr_hi) drv_bad = 1;
      if (usb_acc_gnt != done) gnt_bad = 1;
    end
    tick = 1'b0;
    repeat (3) @(negedge clk);
    chk(n < 6000, "R2 sequence ends", n, 6000);
    chk(lock_err == experr, "R10 error flag", lock_err, experr);
    if (experr) begin
      chk(ta == 20 + int'(lim) - 1, "R10 poll ticks before error", ta, 20 + int'(lim) - 1);
      chk(!usb_clk_en && syn_mode == 2'b11, "R10 halted", usb_clk_en, 0);
      chk(!done && !usb_acc_gnt, "R9 no grant on error", usb_acc_gnt, 0);
    end else begin
      chk(ta == 20 + k, "R3 settle plus poll ticks", ta, 20 + k);
      chk(syn_mode == 2'b10, "R4 mode after lock", syn_mode, 2);
      chk(tb == int'(cap) + 10, "R7 capacitor wait ticks", tb, int'(cap) + 10);
      chk(gap == 4, "R8 clock to core gap", gap, 4);
      chk(usb_en && done && usb_clk_en, "R8 enables held", done, 1);
      chk(ldo_en == ur, ur ? "R5 regulator on" : "R6 regulator skipped", ldo_en, ur);
      chk(usb_acc_gnt == 1'b1, "R9 grant after done", usb_acc_gnt, 1);
    end
    chk(!ldo_early, "R5 regulator not before lock", ldo_early, 0);
    chk(!drv_bad, "R5 current control held 0", drv_bad, 0);
    chk(!gnt_bad, "R9 grant follows done", gnt_bad, 0);
  endtask

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!syn_en && !ldo_en && !usb_clk_en && !usb_en && !done && !lock_err,
        "R1 strobes low in reset", {syn_en, usb_clk_en, usb_en, lock_err}, 0);
    chk(syn_mode == 2'b11, "R1 mode reset", syn_mode, 3);
    rst_n = 1'b1;
    chk(!syn_en, "R2 enable low at release", syn_en, 0);
    @(negedge clk);
    chk(syn_en, "R2 enable one edge after release", syn_en, 1);

    for (int i = 0; i < 7; i++)
      run_case(VEC[i][25], VEC[i][24:17], int'(VEC[i][16:9]), VEC[i][8:1], VEC[i][0]);

    // R9 request dropped after done
    usb_acc_req = 1'b0;
    #1;
    chk(!usb_acc_gnt, "R9 no request no grant", usb_acc_gnt, 0);

    // R1 reset in the middle of the capacitor wait
    use_reg = 1'b1;
    cap_tenths = 8'd50;
    lock_limit = 8'd0;
    do_reset();
    pll_lock = 1'b1;
    for (int n = 1; n <= 120; n++) begin
      @(negedge clk);
      tick = (n % 4 == 0);
    end
    chk(syn_mode == 2'b10 && ldo_en, "R5 regulator up mid run", ldo_en, 1);
    rst_n = 1'b0;
    tick = 1'b0;
    #1;
    chk(!syn_en && !ldo_en && syn_mode == 2'b11 && !usb_clk_en,
        "R1 reset mid run", {syn_en, ldo_en, syn_mode}, 3);
    @(negedge clk);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule